// File: doc/BRIEF.md
# Pulse-Swallow Programmable Clock Divider

This block divides a fast input clock by any integer between 16 and 159. Internally it is a pulse-swallow divider. A prescaler counts either 4 or 5 input clocks per output tick. A single down-counter, advanced by those ticks, sets both the length of the division period and how many of its prescaler cycles use the longer modulus. For a ratio N, the counter loads P = N div 4 at the start of each period. The first S = N mod 4 prescaler cycles run at modulus 5 and the rest run at modulus 4, which gives 5S + 4(P - S) = N input clocks per period. When S is zero the prescaler never leaves modulus 4. This is what lets the range start at 16.

A system samples the 8-bit ratio word only at a period boundary, so every period uses a single ratio throughout. A word outside the legal range is flagged and ignored, and the divider keeps the last legal ratio it accepted. The output is a registered pulse, one input clock wide, once per period. Everything runs in one clock domain with a synchronous active-high reset.

Top module: `pswdiv_top`

## Requirements
- R1: For an active ratio N, `div_pulse_o` rises exactly once every N clock cycles. The ratio word is an unsigned binary number on `ratio_i`.
- R2: `div_pulse_o` is high for exactly one clock cycle per period.
- R3: Ratios that are multiples of 4 (swallow count zero) divide correctly, and the prescaler never selects modulus 5 during such a period.
- R4: Every integer ratio from 16 to 159 inclusive produces its exact period, with no gaps in the range.
- R5: `ratio_i` is sampled only on the clock edge that ends a period. A change in mid-period leaves the current period at the old ratio, and the next period uses the new one.
- R6: A `ratio_i` value below 16 or above 159 drives `ratio_ok_o` low on the following cycle. The divider keeps running at the last legal ratio.
- R7: A legal `ratio_i` value drives `ratio_ok_o` high on the following cycle.
- R8: While `rst_i` is high, `div_pulse_o` and `ratio_ok_o` are low and the divider reloads from `ratio_i` (or a default legal ratio if that word is illegal). The first pulse appears on the N-th clock edge after the last edge at which reset is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| ratio_i | input | 8 | Requested division ratio, unsigned |
| div_pulse_o | output | 1 | One-cycle pulse per division period |
| ratio_ok_o | output | 1 | High when the previous cycle's ratio word was legal |

## Verification
The bench builds the block with its default parameters: an 8-bit ratio word, prescaler moduli 4 and 5, and limits of 16 and 159. With these values every legal ratio can be swept and each period measured in a few tens of thousands of cycles. That covers all swallow counts, including the zero case. It also reaches both range edges and the illegal words just outside them, and a per-cycle reference model checks ratio changes made in mid-period against the boundary-only sampling rule.

// File: rtl/pswdiv_pkg.sv
package pswdiv_pkg;

  // Prescaler modulus selection
  typedef enum logic {
    MOD_LO = 1'b0,
    MOD_HI = 1'b1
  } mod_e;

  // True when value lies inside the closed legal interval
  function automatic logic in_range(input int value, input int lo, input int hi);
    return (value >= lo) && (value <= hi);
  endfunction

endpackage

// File: rtl/pswdiv_ratio_ctl.sv
module pswdiv_ratio_ctl
  import pswdiv_pkg::*;
#(
  parameter int RATIO_W     = 8,
  parameter int PRE_LO      = 4,
  parameter int MIN_RATIO   = 16,
  parameter int MAX_RATIO   = 159,
  parameter int DEF_RATIO   = 16,
  parameter int CNT_W       = 6
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               bound_i,
  output logic [CNT_W-1:0]   load_val_o,
  output logic [CNT_W-1:0]   thr_o,
  output logic [RATIO_W-1:0] act_ratio_o,
  output logic               ok_o
);

  logic               legal;
  logic [RATIO_W-1:0] sel_ratio;
  logic [RATIO_W-1:0] act_q;
  logic [CNT_W-1:0]   thr_q;
  logic               ok_q;
  int                 p_int;
  int                 s_int;

  assign legal = in_range(int'(ratio_i), MIN_RATIO, MAX_RATIO);

  // Ratio in force for the next period
  always_comb begin
    if (legal)
      sel_ratio = ratio_i;
    else if (rst_i)
      sel_ratio = RATIO_W'(DEF_RATIO);
    else
      sel_ratio = act_q;
    p_int = int'(sel_ratio) / PRE_LO;
    s_int = int'(sel_ratio) % PRE_LO;
  end

  assign load_val_o = CNT_W'(p_int);

  always_ff @(posedge clk_i) begin
    if (rst_i || bound_i) begin
      act_q <= sel_ratio;
      // Count above this threshold selects the long modulus
      thr_q <= CNT_W'(p_int - s_int);
    end
    if (rst_i)
      ok_q <= 1'b0;
    else
      ok_q <= legal;
  end

  assign thr_o       = thr_q;
  assign act_ratio_o = act_q;
  assign ok_o        = ok_q;

endmodule

// File: rtl/pswdiv_prescaler.sv
module pswdiv_prescaler
  import pswdiv_pkg::*;
#(
  parameter int PRE_LO = 4,
  parameter int PH_W   = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  mod_e mod_i,
  output logic tick_o
);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] last_phase;

  assign last_phase = (mod_i == MOD_HI) ? PH_W'(PRE_LO) : PH_W'(PRE_LO - 1);
  assign tick_o     = (phase_q == last_phase);

  always_ff @(posedge clk_i) begin
    if (rst_i || tick_o)
      phase_q <= '0;
    else
      phase_q <= phase_q + 1'b1;
  end

endmodule

// File: rtl/pswdiv_counter.sv
module pswdiv_counter
  import pswdiv_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] thr_i,
  output mod_e             mod_o,
  output logic             bound_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             term;

  assign term    = (cnt_q == CNT_W'(1));
  assign bound_o = tick_i && term;
  assign mod_o   = (cnt_q > thr_i) ? MOD_HI : MOD_LO;

  always_ff @(posedge clk_i) begin
    if (rst_i || bound_o)
      cnt_q <= load_val_i;
    else if (tick_i)
      cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/pswdiv_top.sv
module pswdiv_top
  import pswdiv_pkg::*;
#(
  parameter int RATIO_W   = 8,
  parameter int PRE_LO    = 4,
  parameter int MIN_RATIO = 16,
  parameter int MAX_RATIO = 159,
  parameter int DEF_RATIO = 16
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               div_pulse_o,
  output logic               ratio_ok_o
);

  localparam int CNT_W = $clog2(MAX_RATIO / PRE_LO + 1);
  localparam int PH_W  = $clog2(PRE_LO + 1);

  logic [CNT_W-1:0]   load_val;
  logic [CNT_W-1:0]   thr;
  logic [RATIO_W-1:0] act_ratio;
  logic               tick;
  logic               bound;
  logic               mod_hi;
  mod_e               mod_sel;
  logic               pulse_q;

  pswdiv_ratio_ctl #(
    .RATIO_W  (RATIO_W),
    .PRE_LO   (PRE_LO),
    .MIN_RATIO(MIN_RATIO),
    .MAX_RATIO(MAX_RATIO),
    .DEF_RATIO(DEF_RATIO),
    .CNT_W    (CNT_W)
  ) ctl_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .ratio_i    (ratio_i),
    .bound_i    (bound),
    .load_val_o (load_val),
    .thr_o      (thr),
    .act_ratio_o(act_ratio),
    .ok_o       (ratio_ok_o)
  );

  pswdiv_prescaler #(
    .PRE_LO(PRE_LO),
    .PH_W  (PH_W)
  ) pre_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .mod_i (mod_sel),
    .tick_o(tick)
  );

  pswdiv_counter #(
    .CNT_W(CNT_W)
  ) cnt_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .tick_i    (tick),
    .load_val_i(load_val),
    .thr_i     (thr),
    .mod_o     (mod_sel),
    .bound_o   (bound)
  );

  assign mod_hi = (mod_sel == MOD_HI);

  always_ff @(posedge clk_i) begin
    if (rst_i)
      pulse_q <= 1'b0;
    else
      pulse_q <= bound;
  end

  assign div_pulse_o = pulse_q;

endmodule

// File: rtl/pswdiv_chk.sv
module pswdiv_chk #(
  parameter int RATIO_W   = 8,
  parameter int PRE_LO    = 4,
  parameter int MIN_RATIO = 16,
  parameter int MAX_RATIO = 159
) (
  input logic               clk,
  input logic               rst,
  input logic [RATIO_W-1:0] ratio,
  input logic               pulse,
  input logic               ok,
  input logic               mod_hi,
  input logic               bound,
  input logic [RATIO_W-1:0] act_ratio
);

  logic [15:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= pulse ? 16'd0 : gap_q + 16'd1;
      if (pulse) seen_q <= 1'b1;
    end
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R1
  pulse_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse && seen_q) |-> (int'(gap_q) >= MIN_RATIO - 1 && int'(gap_q) <= MAX_RATIO - 1));

  // R3
  s_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(act_ratio) % PRE_LO == 0) |-> !mod_hi);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(ratio) < MIN_RATIO || int'(ratio) > MAX_RATIO) |=> !ok);

  // R5
  ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bound |=> $stable(act_ratio));

  // R6
  ratio_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(act_ratio) >= MIN_RATIO && int'(act_ratio) <= MAX_RATIO));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!pulse && !ok));

endmodule

bind pswdiv_top pswdiv_chk #(
  .RATIO_W  (RATIO_W),
  .PRE_LO   (PRE_LO),
  .MIN_RATIO(MIN_RATIO),
  .MAX_RATIO(MAX_RATIO)
) chk_i (
  .clk      (clk_i),
  .rst      (rst_i),
  .ratio    (ratio_i),
  .pulse    (div_pulse_o),
  .ok       (ratio_ok_o),
  .mod_hi   (mod_hi),
  .bound    (bound),
  .act_ratio(act_ratio)
);

// File: tb/pswdiv_top_tb_top.sv
module pswdiv_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_R      = 16;
  localparam int MAX_R      = 159;
  localparam int DEF_R      = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ratio = 8'd37;
  logic       div_o;
  logic       ok_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit model_on = 1'b0;
  bit done     = 1'b0;

  // Reference model state
  int m_ticks = 0;
  int m_n     = DEF_R;
  bit m_div   = 1'b0;
  bit m_ok    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pswdiv_top dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .ratio_i    (ratio),
    .div_pulse_o(div_o),
    .ratio_ok_o (ok_o)
  );

  function automatic bit legal(input int r);
    return (r >= MIN_R) && (r <= MAX_R);
  endfunction

  // Behavioural model: count edges, pulse on the N-th, take new ratio there
  always @(posedge clk) begin
    model_on = 1'b1;
    if (rst) begin
      m_ticks = 0;
      m_n     = legal(int'(ratio)) ? int'(ratio) : DEF_R;
      m_div   = 1'b0;
      m_ok    = 1'b0;
    end else begin
      m_ticks = m_ticks + 1;
      m_div   = (m_ticks == m_n);
      if (m_div) begin
        m_ticks = 0;
        if (legal(int'(ratio))) m_n = int'(ratio);
      end
      m_ok = legal(int'(ratio));
    end
  end

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (model_on && !done) begin
      check(div_o == m_div, "R1 pulse vs model", int'(div_o), int'(m_div));
      check(ok_o == m_ok, "R7 flag vs model", int'(ok_o), int'(m_ok));
    end
  end

  task automatic measure(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!div_o && gap < 1000);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    int g;
    int prev;
    int bad_list[4] = '{0, 15, 160, 255};

    // R8: reset state and first pulse position
    rst   = 1'b1;
    ratio = 8'd37;
    repeat (4) @(negedge clk);
    check(div_o == 1'b0, "R8 pulse low in reset", int'(div_o), 0);
    check(ok_o == 1'b0, "R8 flag low in reset", int'(ok_o), 0);
    rst = 1'b0;
    measure(g);
    check(g == 37, "R8 first pulse delay", g, 37);

    // R2: one-cycle-wide pulse
    @(negedge clk);
    check(div_o == 1'b0, "R2 pulse width", int'(div_o), 0);
    measure(g);
    check(g == 36, "R1 period remainder", g, 36);

    // R4 / R3: sweep the whole legal range
    prev = 37;
    for (int n = MIN_R; n <= MAX_R; n++) begin
      ratio = 8'(n);
      measure(g);
      check(g == prev, "R5 old ratio to boundary", g, prev);
      measure(g);
      if (n % 4 == 0)
        check(g == n, "R3 swallow zero ratio", g, n);
      else
        check(g == n, "R4 ratio sweep", g, n);
      prev = n;
    end

    // R5: change in mid-period
    ratio = 8'd40;
    measure(g);
    measure(g);
    check(g == 40, "R1 ratio 40", g, 40);
    repeat (10) @(negedge clk);
    ratio = 8'd23;
    measure(g);
    check(g == 30, "R5 mid-period change", g, 30);
    measure(g);
    check(g == 23, "R5 new ratio applied", g, 23);

    // R6: illegal words ignored
    ratio = 8'd30;
    measure(g);
    measure(g);
    check(g == 30, "R1 ratio 30", g, 30);
    foreach (bad_list[i]) begin
      ratio = 8'(bad_list[i]);
      @(negedge clk);
      check(ok_o == 1'b0, "R6 flag cleared", int'(ok_o), 0);
      measure(g);
      check(g == 29, "R6 ratio held", g, 29);
      measure(g);
      check(g == 30, "R6 ratio held next period", g, 30);
    end

    // R7: flag returns on legal word
    ratio = 8'd30;
    @(negedge clk);
    check(ok_o == 1'b1, "R7 flag set", int'(ok_o), 1);
    measure(g);
    check(g == 29, "R7 ratio unchanged", g, 29);

    done = 1'b1;
    report();
    $finish;
  end

endmodule